// File: doc/BRIEF.md
# Background Tile Fetch and Pixel Decoder

This block is the background layer tile unit of a raster video pipeline. For each tile it captures two attribute bytes from background video RAM. The first byte is the tile code. The second byte holds the upper tile-code bits, the palette, a mirror flag and a priority flag. Each byte is captured on its own strobe, and the strobes are derived from two slow phase clocks. The block joins the captured tile code with the scroll position bits to form a 17-bit graphics ROM address. From the 16-bit word the ROM returns, it picks one 4-bit colour index on every pixel step.

All inputs are sampled on a single fast system clock, and the strobes are found by edge detection:

- The first byte is captured when the slow 1.5 MHz phase falls. This is the rising edge of its inverse.
- The second byte is captured when the NAND of the 1.5 MHz and 3 MHz phases rises.
- A pixel step happens on each rising edge of the inverted pixel clock.

Palette, priority and the mirror flag are moved into the output stage at the tile boundary. This keeps them aligned with the tile's first pixel. A screen-flip input and the per-tile mirror flag each reverse the order in which pixels are picked. When both are set, the two reversals cancel.

Top module: `bg_tile_unit`

## Requirements
- R1: A synchronous active-high reset clears both attribute bytes, sets colour, palette and priority to 0, and clears the mirror flag in the output stage.
- R2: On a clock edge where phaseM was 1 in the previous cycle and is 0 now, attrIn is captured as the first byte and drives romAddr[13:6]. The output changes after that edge.
- R3: On a clock edge where NAND(phaseM, phaseH) was 0 in the previous cycle and is 1 now, attrIn is captured as the second byte. Its bits [2:0] drive romAddr[16:14].
- R4: romAddr[3:0] always equals vPos[3:0], and romAddr[5:4] always equals hPos[2:1]. Neither is registered.
- R5: On a pixel step (pixClkN was 0 and is now 1), colour takes romData[4k+3:4k], where k = {hPos[3], hPos[0]} XOR {r, r}.
- R6: In R5, r is flip XOR m, where m is the mirror flag in effect. With m = 0, setting flip reverses the order in which the four nibbles are picked.
- R7: The mirror flag is bit 6 of the second byte. It takes effect at the tile boundary and reverses the order like flip does. With flip and the mirror flag both set, the order is the normal one.
- R8: A tile boundary is a pixel step with hPos = 0. At that step, palette takes bits [5:3] of the second byte, priority takes bit 7, and the mirror flag takes bit 6. If a second-byte capture falls on the same edge, the value captured before that edge is used.
- R9: Colour keeps its value on every edge that is not a pixel step. Palette and priority keep theirs on every edge that is not a tile boundary.
- R10: A change of attrIn without a capture strobe has no effect on romAddr.
- R11: When phaseM falls while phaseH is high, both strobes fire on the same edge, and both bytes take the same attrIn value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous reset, active high |
| phaseM | input | 1 | 1.5 MHz phase clock (level) |
| phaseH | input | 1 | 3 MHz phase clock (level) |
| pixClkN | input | 1 | Inverted pixel clock; its rising edge is a pixel step |
| attrIn | input | 8 | Attribute byte from background video RAM |
| vPos | input | 4 | Vertical position within the tile |
| hPos | input | 4 | Horizontal position within the tile |
| flip | input | 1 | Screen flip, active high |
| romData | input | 16 | Graphics ROM word: four 4-bit pixels |
| romAddr | output | 17 | Graphics ROM address |
| colour | output | 4 | Colour index; 0 is transparent |
| palette | output | 3 | Palette select for the current tile |
| prio | output | 1 | Priority flag for the current tile |

## Verification
Two pairs of functions can fall on the same edge.

The first pair is the tile-boundary update and a second-byte capture. The bench drops phaseH in the same cycle that it raises pixClkN with hPos at 0. It then expects the palette and priority of the previous tile at that step, and the new ones only at the next boundary.

The second pair is the two capture strobes. The bench lowers phaseM and phaseH together and expects both halves of romAddr to take the same byte. The bench also checks that the mirror flag, once applied at the boundary, combines with flip so that the two cancel.

// File: rtl/bg_tile_pkg.sv
package bg_tile_pkg;
  localparam int ATTR_W = 8;
  localparam int POS_W  = 4;
  localparam int PIX_W  = 4;
  localparam int PAL_W  = 3;
  localparam int ROM_W  = 4 * PIX_W;
  localparam int ADDR_W = 3 + ATTR_W + 2 + POS_W;

  typedef struct packed {
    logic latchLo;
    logic latchHi;
    logic pixStep;
    logic tileStart;
  } strobe_t;
endpackage

// File: rtl/bg_tile_ctrl.sv
module bg_tile_ctrl
  import bg_tile_pkg::*;
#(
  parameter int POS_W_P = POS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               phaseM,
  input  logic               phaseH,
  input  logic               pixClkN,
  input  logic [POS_W_P-1:0] hPos,
  output strobe_t            stb
);
  logic prevM, prevNand, prevPix;
  logic nandNow;

  assign nandNow = ~(phaseM & phaseH);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevM    <= 1'b0;
      prevNand <= 1'b1;
      prevPix  <= 1'b1;
    end else begin
      prevM    <= phaseM;
      prevNand <= nandNow;
      prevPix  <= pixClkN;
    end
  end

  always_comb begin
    stb.latchLo   = prevM & ~phaseM;
    stb.latchHi   = ~prevNand & nandNow;
    stb.pixStep   = ~prevPix & pixClkN;
    stb.tileStart = stb.pixStep && (hPos == '0);
  end

  // R3: the NAND strobe cannot fire on two edges in a row
  a_r3_hi_single: assert property (@(posedge clk) disable iff (rst)
    stb.latchHi |=> !stb.latchHi);
  // R5: pixel steps are single-cycle pulses
  a_r5_step_pulse: assert property (@(posedge clk) disable iff (rst)
    stb.pixStep |=> !stb.pixStep);
endmodule

// File: rtl/bg_tile_datapath.sv
module bg_tile_datapath
  import bg_tile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [ATTR_W-1:0] attrIn,
  input  logic [POS_W-1:0]  vPos,
  input  logic [POS_W-1:0]  hPos,
  input  logic              flip,
  input  logic [ROM_W-1:0]  romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [PIX_W-1:0]  colour,
  output logic [PAL_W-1:0]  palette,
  output logic              prio
);
  logic [ATTR_W-1:0] loByte, hiByte;
  logic              invQ, curInv, rev;
  logic [1:0]        k;
  logic [PIX_W-1:0]  pick;

  assign romAddr = {hiByte[2:0], loByte, hPos[2:1], vPos};

  always_comb begin
    curInv = stb.tileStart ? hiByte[6] : invQ;
    rev    = flip ^ curInv;
    k      = {hPos[3], hPos[0]} ^ {rev, rev};
    pick   = romData[{k, 2'b00} +: PIX_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loByte  <= '0;
      hiByte  <= '0;
      invQ    <= 1'b0;
      palette <= '0;
      prio    <= 1'b0;
      colour  <= '0;
    end else begin
      if (stb.latchLo) loByte <= attrIn;
      if (stb.latchHi) hiByte <= attrIn;
      if (stb.tileStart) begin
        palette <= hiByte[5:3];
        prio    <= hiByte[7];
        invQ    <= hiByte[6];
      end
      if (stb.pixStep) colour <= pick;
    end
  end

  // R1: one edge after reset the outputs are cleared
  logic rstQ;
  always_ff @(posedge clk) rstQ <= rst;
  always @(posedge clk)
    if (rstQ) a_r1_reset_clears: assert (colour == '0 && palette == '0 && !prio);

  // R9
  a_r9_colour_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.pixStep |=> $stable(colour));
  a_r9_pal_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.tileStart |=> $stable(palette) && $stable(prio));
  // R10
  a_r10_lo_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.latchLo |=> $stable(romAddr[13:6]));
  a_r10_hi_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.latchHi |=> $stable(romAddr[16:14]));
endmodule

// File: rtl/bg_tile_unit.sv
module bg_tile_unit
  import bg_tile_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        phaseM,
  input  logic        phaseH,
  input  logic        pixClkN,
  input  logic [7:0]  attrIn,
  input  logic [3:0]  vPos,
  input  logic [3:0]  hPos,
  input  logic        flip,
  input  logic [15:0] romData,
  output logic [16:0] romAddr,
  output logic [3:0]  colour,
  output logic [2:0]  palette,
  output logic        prio
);
  strobe_t stb;

  bg_tile_ctrl #(.POS_W_P(POS_W)) u_ctrl (
    .clk(clk), .rst(rst), .phaseM(phaseM), .phaseH(phaseH),
    .pixClkN(pixClkN), .hPos(hPos), .stb(stb)
  );

  bg_tile_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .attrIn(attrIn), .vPos(vPos),
    .hPos(hPos), .flip(flip), .romData(romData), .romAddr(romAddr),
    .colour(colour), .palette(palette), .prio(prio)
  );
endmodule

// File: tb/test_bg_tile_unit.sv
module test_bg_tile_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1, phaseM = 0, phaseH = 0, pixClkN = 0, flip = 0;
  logic [7:0]  attrIn = 0;
  logic [3:0]  vPos = 0, hPos = 0;
  logic [15:0] romData = 0;
  logic [16:0] romAddr;
  logic [3:0]  colour;
  logic [2:0]  palette;
  logic        prio;

  int vectors = 0, miscompares = 0;
  logic [7:0]  expQ[$];
  string       tagQ[$];
  logic        armed = 0;
  logic        done = 0;

  bg_tile_unit i_bg_tile_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares {colour,palette,prio} after each pixel-step edge
  always @(posedge clk) begin
    #1;
    if (armed) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, {24'd0, colour, palette, prio}, {24'd0, e});
      armed = 0;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [3:0] expPix(logic [15:0] d, logic [3:0] h, logic f, logic m);
    logic [1:0] kk;
    kk = {h[3], h[0]} ^ {2{f ^ m}};
    return d[kk*4 +: 4];
  endfunction

  // second byte first, then first byte, like a real fetch
  task automatic fetch(logic [7:0] lo, logic [7:0] hi);
    attrIn = hi; phaseM = 1; phaseH = 1; tick();
    phaseH = 0; tick();
    attrIn = lo; tick();
    phaseM = 0; tick();
    attrIn = 8'hEE; tick();
  endtask

  task automatic pix(string tag, logic [3:0] h, logic [15:0] d, logic [3:0] ec,
                     logic [2:0] ep, logic epr);
    hPos = h; romData = d; pixClkN = 1;
    expQ.push_back({ec, ep, epr}); tagQ.push_back(tag); armed = 1;
    tick();
    pixClkN = 0; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [3:0] c0;
    tick(); tick(); rst = 0; hPos = 4'b0110; vPos = 4'h9; tick();
    check("R1 colour", colour, 0);
    check("R1 palette/prio", {palette, prio}, 0);
    check("R1 addr", romAddr, {3'd0, 8'd0, 2'b11, 4'h9});

    // hi=0xAB: addrHi=3, pal=5, mirror=0, prio=1
    fetch(8'hA5, 8'hAB);
    check("R2 R3 addr", romAddr, {3'd3, 8'hA5, 2'b11, 4'h9});
    attrIn = 8'h3C; tick(); tick();
    check("R10 attr ignored", romAddr, {3'd3, 8'hA5, 2'b11, 4'h9});
    vPos = 4'h2; hPos = 4'b1100; #1;
    check("R4 addr pos", romAddr, {3'd3, 8'hA5, 2'b10, 4'h2});

    pix("R5 R8 boundary h0", 4'h0, 16'h4321, 4'h1, 3'd5, 1'b1);
    pix("R5 h1", 4'h1, 16'h4321, 4'h2, 3'd5, 1'b1);
    pix("R5 h8", 4'h8, 16'h4321, 4'h3, 3'd5, 1'b1);
    pix("R5 h9", 4'h9, 16'h4321, 4'h4, 3'd5, 1'b1);
    c0 = colour; romData = 16'hFFFF; hPos = 4'h0; tick(); tick();
    check("R9 colour hold", colour, c0);
    flip = 1;
    pix("R6 flip h1", 4'h1, 16'h4321, expPix(16'h4321, 4'h1, 1, 0), 3'd5, 1'b1);
    pix("R6 flip h0", 4'h0, 16'h8765, 4'h8, 3'd5, 1'b1);
    flip = 0;

    // hi=0x52: mirror=1, pal=2, prio=0, addrHi=2
    fetch(8'h11, 8'h52);
    check("R2 R3 addr 2", romAddr[16:6], {3'd2, 8'h11});
    check("R9 pal before boundary", {palette, prio}, {3'd5, 1'b0} | 4'd1);
    pix("R7 mirror h0", 4'h0, 16'h4321, 4'h4, 3'd2, 1'b0);
    pix("R7 mirror h9", 4'h9, 16'h4321, 4'h1, 3'd2, 1'b0);
    flip = 1;
    pix("R7 mirror+flip h1", 4'h1, 16'h4321, 4'h2, 3'd2, 1'b0);
    flip = 0;

    // R8: capture of hi=0xA0 on the same edge as a boundary
    attrIn = 8'hA0; phaseM = 1; phaseH = 1; tick();
    phaseH = 0; hPos = 4'h0; romData = 16'h4321; pixClkN = 1;
    expQ.push_back({4'h4, 3'd2, 1'b0}); tagQ.push_back("R8 same-edge old attr"); armed = 1;
    tick(); pixClkN = 0; tick();
    pix("R8 next boundary new attr", 4'h0, 16'h4321, 4'h1, 3'd4, 1'b1);

    // R11: both strobes on the same edge
    attrIn = 8'h6D; phaseM = 1; phaseH = 1; tick();
    phaseM = 0; phaseH = 0; tick();
    attrIn = 8'h00; tick();
    check("R11 both bytes", romAddr[16:6], {3'd5, 8'h6D});

    rst = 1; tick(); rst = 0; #1;
    check("R1 reset mid-run", {colour, palette, prio}, 0);
    check("R1 addr cleared", romAddr[16:6], 0);

    tick(); tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule